// File: doc/BRIEF.md
# Double-Buffered Sprite Line Buffer

This block holds two scanlines of sprite pixels. One scanline is drawn while the other is scanned out to video, and a flip bit swaps the two roles on every new line. Each scanline is built from an even half and an odd half. That gives four independent storage lanes, each with its own pointer, clock enable and write enable. As a result, two pixels can be drawn per clock in any order, and output can alternate between the even and odd halves.

A sprite engine loads a lane pair's pointers from a position bus and then steps the lanes. The combination of clock enable and write enable on each lane selects one of three actions. Both together store an opaque pixel. The clock alone skips a transparent pixel. Neither leaves the lane untouched, which is how a pixel is dropped for horizontal shrinking. On the scan-out side, each clocked lane presents its entry on the pixel output one cycle later and leaves the backdrop index in its place. The buffer is therefore clean when its next drawing turn begins.

Top module: `sprlb_linebuf`

## Requirements
- R1: Lanes 0 and 1 form pair 0 and lanes 2 and 3 form pair 1. With `flip_i` = 0, pair 0 draws and pair 1 scans out. With `flip_i` = 1 the roles are reversed. A drawing lane never produces output.
- R2: While `ld_n_i[p]` is low at a clock edge, both pointers of pair p load from `pos_i`: the even lane takes bits [PTR_W-1:0] and the odd lane takes bits [2*PTR_W-1:PTR_W]. A load takes precedence over that cycle's lane clock, so nothing is stored or read out in that cycle.
- R3: A drawing lane with its clock enable and write enable high, and a nonzero colour index on its `pix_i` slice (lane k uses bits [4k+3:4k]), stores that index at its pointer and advances the pointer by one.
- R4: A drawing lane that is clocked without a write enable, or with colour index 0, advances its pointer and leaves the stored contents unchanged.
- R5: A lane whose clock enable is low keeps its pointer and its contents unchanged, whatever its write enable and colour inputs are.
- R6: A lane whose pointer is at or beyond HALF discards drawn pixels and reads out the backdrop index 0.
- R7: A clocked scan-out lane drives its stored index on `px_o` with `px_vld_o` high after that edge, and overwrites the location with backdrop 0. Its write enable and colour inputs are ignored.
- R8: With no scan-out lane clocked, `px_vld_o` and `px_o` are 0 after the edge. If several scan-out lanes are clocked together, the lowest lane number drives `px_o`, and every clocked lane still advances and clears.
- R9: Reset clears every pointer to 0, fills every entry with backdrop 0 and drives `px_vld_o` and `px_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flip_i | input | 1 | Role select: 0 means pair 0 draws and pair 1 scans out |
| ld_n_i | input | 2 | Active-low pointer load, one bit per lane pair |
| pos_i | input | 2*PTR_W | Pointer values: even lane in the low field, odd lane in the high field |
| ck_i | input | 4 | Per-lane clock enable |
| we_i | input | 4 | Per-lane write enable (drawing lanes only) |
| pix_i | input | 4*CW | Per-lane colour index, lane k at [CW*k +: CW] |
| px_o | output | CW | Scanned-out colour index |
| px_vld_o | output | 1 | A scan-out lane produced `px_o` on the last edge |

## Verification
The bench builds the block with HALF = 12 and PTR_W = 5, keeping CW = 4. With these values a short vector table can reach the end of every half and push a pointer past it, covering the discarded writes and backdrop reads of R6. A full readout of the stored pixels also stays short, so the clear-behind-read rule can be confirmed by a second pass over the same locations. The defaults (160 entries, 8-bit pointers) change only the sizes, not any of the control paths.

// File: rtl/sprlb_pkg.sv
package sprlb_pkg;

  typedef enum logic {
    ROLE_DRAW = 1'b0,
    ROLE_SCAN = 1'b1
  } lane_role_e;

  // pair 0 draws while flip is low, pair 1 draws while flip is high
  function automatic lane_role_e role_of(input logic flip, input int pair);
    return ((flip ^ pair[0]) == 1'b1) ? ROLE_SCAN : ROLE_DRAW;
  endfunction

endpackage

// File: rtl/sprlb_lane.sv
module sprlb_lane
  import sprlb_pkg::*;
#(
  parameter int HALF  = 160,
  parameter int PTR_W = 8,
  parameter int CW    = 4,
  parameter logic [CW-1:0] BLANK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lane_role_e       role_i,
  input  logic             ck_i,
  input  logic             we_i,
  input  logic             ld_i,
  input  logic [PTR_W-1:0] pos_i,
  input  logic [CW-1:0]    pix_i,
  output logic [CW-1:0]    rd_px_o,
  output logic             rd_fire_o
);

  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  function automatic logic in_range(input logic [PTR_W-1:0] p);
    return 32'(p) < 32'(HALF);
  endfunction

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_MAX) ? p : p + 1'b1;
  endfunction

  logic [CW-1:0]    mem [HALF];
  logic [PTR_W-1:0] ptr_q;
  logic [CW-1:0]    rd_px_q;
  logic             rd_fire_q;

  // named events
  logic rd_stb, clr_stb, wr_stb;
  assign rd_stb  = !ld_i && ck_i && (role_i == ROLE_SCAN);
  assign clr_stb = rd_stb && in_range(ptr_q);
  assign wr_stb  = !ld_i && ck_i && we_i && (role_i == ROLE_DRAW)
                   && in_range(ptr_q) && (pix_i != BLANK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      rd_px_q   <= BLANK;
      rd_fire_q <= 1'b0;
      for (int i = 0; i < HALF; i++) mem[i] <= BLANK;
    end else begin
      rd_fire_q <= rd_stb;
      if (rd_stb) rd_px_q <= in_range(ptr_q) ? mem[ptr_q] : BLANK;
      if (ld_i)      ptr_q <= pos_i;
      else if (ck_i) ptr_q <= step(ptr_q);
      if (wr_stb)       mem[ptr_q] <= pix_i;
      else if (clr_stb) mem[ptr_q] <= BLANK;
    end
  end

  assign rd_px_o   = rd_px_q;
  assign rd_fire_o = rd_fire_q;

  a_r2_pointer_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (ptr_q == $past(pos_i)));

  a_r5_pointer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !ck_i) |=> $stable(ptr_q));

  a_r3_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (mem[$past(ptr_q)] == $past(pix_i)));

  a_r7_clear_behind: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (mem[$past(ptr_q)] == BLANK));

endmodule

// File: rtl/sprlb_outsel.sv
module sprlb_outsel #(
  parameter int LANES = 4,
  parameter int CW    = 4,
  parameter logic [CW-1:0] BLANK = '0
) (
  input  logic [LANES-1:0]    fire_i,
  input  logic [LANES*CW-1:0] px_i,
  output logic [CW-1:0]       px_o,
  output logic                vld_o
);

  // descending scan so the lowest fired lane is applied last and wins
  always_comb begin
    px_o  = BLANK;
    vld_o = |fire_i;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (fire_i[k]) px_o = px_i[k*CW +: CW];
    end
  end

endmodule

// File: rtl/sprlb_linebuf.sv
module sprlb_linebuf
  import sprlb_pkg::*;
#(
  parameter int HALF  = 160,
  parameter int PTR_W = 8,
  parameter int CW    = 4,
  parameter logic [CW-1:0] BLANK = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flip_i,
  input  logic [1:0]           ld_n_i,
  input  logic [2*PTR_W-1:0]   pos_i,
  input  logic [3:0]           ck_i,
  input  logic [3:0]           we_i,
  input  logic [4*CW-1:0]      pix_i,
  output logic [CW-1:0]        px_o,
  output logic                 px_vld_o
);

  localparam int NPAIR = 2;
  localparam int LANES = 2 * NPAIR;

  logic [LANES-1:0]    lane_fire;
  logic [LANES*CW-1:0] lane_px;
  lane_role_e          lane_role [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int PAIR  = g / 2;
    localparam int PHASE = g % 2;

    assign lane_role[g] = role_of(flip_i, PAIR);

    sprlb_lane #(
      .HALF (HALF),
      .PTR_W(PTR_W),
      .CW   (CW),
      .BLANK(BLANK)
    ) lane_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .role_i   (lane_role[g]),
      .ck_i     (ck_i[g]),
      .we_i     (we_i[g]),
      .ld_i     (!ld_n_i[PAIR]),
      .pos_i    (pos_i[PHASE*PTR_W +: PTR_W]),
      .pix_i    (pix_i[g*CW +: CW]),
      .rd_px_o  (lane_px[g*CW +: CW]),
      .rd_fire_o(lane_fire[g])
    );

    a_r1_draw_lane_silent: assert property (@(posedge clk) disable iff (!rst_n)
      lane_fire[g] |-> ($past(lane_role[g]) == ROLE_SCAN));
  end

  sprlb_outsel #(
    .LANES(LANES),
    .CW   (CW),
    .BLANK(BLANK)
  ) outsel_i (
    .fire_i(lane_fire),
    .px_i  (lane_px),
    .px_o  (px_o),
    .vld_o (px_vld_o)
  );

  a_r8_valid_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    px_vld_o |-> ($past(ck_i) != 4'b0000));

endmodule

// File: tb/sprlb_linebuf_tb_top.sv
module sprlb_linebuf_tb_top;

  localparam int HALF  = 12;
  localparam int PTR_W = 5;
  localparam int CW    = 4;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                flip_i;
  logic [1:0]          ld_n_i;
  logic [2*PTR_W-1:0]  pos_i;
  logic [3:0]          ck_i, we_i;
  logic [4*CW-1:0]     pix_i;
  logic [CW-1:0]       px_o;
  logic                px_vld_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sprlb_linebuf #(.HALF(HALF), .PTR_W(PTR_W), .CW(CW), .BLANK(4'h0)) dut_i (
    .clk(clk), .rst_n(rst_n), .flip_i(flip_i), .ld_n_i(ld_n_i), .pos_i(pos_i),
    .ck_i(ck_i), .we_i(we_i), .pix_i(pix_i), .px_o(px_o), .px_vld_o(px_vld_o)
  );

  typedef struct packed {
    logic       fl;
    logic [1:0] ldn;
    logic [9:0] pos;
    logic [3:0] ck;
    logic [3:0] we;
    logic [15:0] pix;
    logic       ev;
    logic [3:0] ep;
  } vec_t;

  // pos: {odd lane, even lane}, 5 bits each; 10'h042 = {2,2}, 10'h021 = {1,1}, 10'h16B = {11,11}
  localparam int NV = 39;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'b10, 10'h042, 4'b0000, 4'b0000, 16'h0000, 1'b0, 4'h0}, // 0  R2 load pair0 at 2
    '{1'b0, 2'b11, 10'h000, 4'b0011, 4'b0011, 16'h0065, 1'b0, 4'h0}, // 1  R3 store 5/6
    '{1'b0, 2'b11, 10'h000, 4'b0011, 4'b0001, 16'h0097, 1'b0, 4'h0}, // 2  R4 lane1 skip
    '{1'b0, 2'b11, 10'h000, 4'b0000, 4'b0011, 16'h0011, 1'b0, 4'h0}, // 3  R5 shrink
    '{1'b0, 2'b11, 10'h000, 4'b0011, 4'b0011, 16'h0030, 1'b0, 4'h0}, // 4  R4 index 0
    '{1'b1, 2'b10, 10'h000, 4'b0000, 4'b0000, 16'h0000, 1'b0, 4'h0}, // 5  R1 flip, load 0
    '{1'b1, 2'b11, 10'h000, 4'b0001, 4'b1111, 16'hFFFF, 1'b1, 4'h0}, // 6  R7 x0
    '{1'b1, 2'b11, 10'h000, 4'b0010, 4'b1111, 16'hFFFF, 1'b1, 4'h0}, // 7  R7 x1
    '{1'b1, 2'b11, 10'h000, 4'b0001, 4'b1111, 16'hFFFF, 1'b1, 4'h0}, // 8  R7 x2
    '{1'b1, 2'b11, 10'h000, 4'b0010, 4'b1111, 16'hFFFF, 1'b1, 4'h0}, // 9  R7 x3
    '{1'b1, 2'b11, 10'h000, 4'b0001, 4'b0000, 16'h0000, 1'b1, 4'h5}, // 10 R3 x4
    '{1'b1, 2'b11, 10'h000, 4'b0010, 4'b0000, 16'h0000, 1'b1, 4'h6}, // 11 R3 x5
    '{1'b1, 2'b11, 10'h000, 4'b0001, 4'b0000, 16'h0000, 1'b1, 4'h7}, // 12 R4 x6
    '{1'b1, 2'b11, 10'h000, 4'b0010, 4'b0000, 16'h0000, 1'b1, 4'h0}, // 13 R4 x7 transparent
    '{1'b1, 2'b11, 10'h000, 4'b0001, 4'b0000, 16'h0000, 1'b1, 4'h0}, // 14 R4 x8 index 0
    '{1'b1, 2'b11, 10'h000, 4'b0010, 4'b0000, 16'h0000, 1'b1, 4'h3}, // 15 R5 x9
    '{1'b1, 2'b11, 10'h000, 4'b0000, 4'b0000, 16'h0000, 1'b0, 4'h0}, // 16 R8 idle
    '{1'b1, 2'b10, 10'h042, 4'b0001, 4'b0000, 16'h0000, 1'b0, 4'h0}, // 17 R2 load beats clock
    '{1'b1, 2'b11, 10'h000, 4'b0001, 4'b0000, 16'h0000, 1'b1, 4'h0}, // 18 R7 cleared
    '{1'b1, 2'b11, 10'h000, 4'b0010, 4'b0000, 16'h0000, 1'b1, 4'h0}, // 19 R7 cleared
    '{1'b0, 2'b10, 10'h16B, 4'b0000, 4'b0000, 16'h0000, 1'b0, 4'h0}, // 20 R6 load 11
    '{1'b0, 2'b11, 10'h000, 4'b0011, 4'b0011, 16'h0044, 1'b0, 4'h0}, // 21 R6 last slot
    '{1'b0, 2'b11, 10'h000, 4'b0011, 4'b0011, 16'h0088, 1'b0, 4'h0}, // 22 R6 past end
    '{1'b1, 2'b10, 10'h16B, 4'b0000, 4'b0000, 16'h0000, 1'b0, 4'h0}, // 23 R6 reload 11
    '{1'b1, 2'b11, 10'h000, 4'b0001, 4'b0000, 16'h0000, 1'b1, 4'h4}, // 24 R6
    '{1'b1, 2'b11, 10'h000, 4'b0010, 4'b0000, 16'h0000, 1'b1, 4'h4}, // 25 R6
    '{1'b1, 2'b11, 10'h000, 4'b0001, 4'b0000, 16'h0000, 1'b1, 4'h0}, // 26 R6 backdrop
    '{1'b1, 2'b11, 10'h000, 4'b0010, 4'b0000, 16'h0000, 1'b1, 4'h0}, // 27 R6 backdrop
    '{1'b1, 2'b01, 10'h000, 4'b0000, 4'b0000, 16'h0000, 1'b0, 4'h0}, // 28 R1 pair1 load 0
    '{1'b1, 2'b01, 10'h021, 4'b1100, 4'b1100, 16'hFF00, 1'b0, 4'h0}, // 29 R2 precedence
    '{1'b1, 2'b11, 10'h000, 4'b1100, 4'b1100, 16'hBA00, 1'b0, 4'h0}, // 30 R3 A/B at 1
    '{1'b0, 2'b01, 10'h000, 4'b0000, 4'b0000, 16'h0000, 1'b0, 4'h0}, // 31 R1 flip back
    '{1'b0, 2'b11, 10'h000, 4'b0100, 4'b1111, 16'hFFFF, 1'b1, 4'h0}, // 32 R2 no F at 0
    '{1'b0, 2'b11, 10'h000, 4'b1000, 4'b1111, 16'hFFFF, 1'b1, 4'h0}, // 33 R2 no F at 0
    '{1'b0, 2'b11, 10'h000, 4'b1100, 4'b0000, 16'h0000, 1'b1, 4'hA}, // 34 R8 lowest wins
    '{1'b0, 2'b11, 10'h000, 4'b1000, 4'b0000, 16'h0000, 1'b1, 4'h0}, // 35 R8 lane3 advanced
    '{1'b0, 2'b01, 10'h021, 4'b0000, 4'b0000, 16'h0000, 1'b0, 4'h0}, // 36 R2 reload 1
    '{1'b0, 2'b11, 10'h000, 4'b1000, 4'b0000, 16'h0000, 1'b1, 4'h0}, // 37 R8 loser cleared
    '{1'b0, 2'b11, 10'h000, 4'b0100, 4'b0000, 16'h0000, 1'b1, 4'h0}  // 38 R7 winner cleared
  };

  task automatic check(input string rq, input logic ev, input logic [3:0] ep);
    checks++;
    if (px_vld_o !== ev || px_o !== ep) begin
      fails++;
      $display("FAIL %s: actual vld=%0b px=%0h expected vld=%0b px=%0h",
               rq, px_vld_o, px_o, ev, ep);
    end
  endtask

  task automatic idle_inputs();
    flip_i = 1'b0; ld_n_i = 2'b11; pos_i = '0; ck_i = '0; we_i = '0; pix_i = '0;
  endtask

  task automatic drive(input vec_t v);
    flip_i = v.fl; ld_n_i = v.ldn; pos_i = v.pos;
    ck_i = v.ck; we_i = v.we; pix_i = v.pix;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset outputs", 1'b0, 4'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      check($sformatf("R1-R9 table row %0d", i), TBL[i].ev, TBL[i].ep);
    end

    // R9: pixel drawn before a reset must read back as backdrop afterwards
    drive('{1'b0, 2'b10, 10'h000, 4'b0000, 4'b0000, 16'h0000, 1'b0, 4'h0});
    drive('{1'b0, 2'b11, 10'h000, 4'b0001, 4'b0001, 16'h0009, 1'b0, 4'h0});
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 outputs during reset", 1'b0, 4'h0);
    rst_n = 1'b1;
    drive('{1'b1, 2'b11, 10'h000, 4'b0001, 4'b0000, 16'h0000, 1'b0, 4'h0});
    check("R9 pointer zero, entry cleared", 1'b1, 4'h0);

    // R5: write enable without clock on a drawing lane stores nothing
    drive('{1'b0, 2'b10, 10'h000, 4'b0000, 4'b0000, 16'h0000, 1'b0, 4'h0});
    drive('{1'b0, 2'b11, 10'h000, 4'b0000, 4'b0011, 16'h00CC, 1'b0, 4'h0});
    check("R5 no clock no output", 1'b0, 4'h0);
    drive('{1'b1, 2'b10, 10'h000, 4'b0000, 4'b0000, 16'h0000, 1'b0, 4'h0});
    drive('{1'b1, 2'b11, 10'h000, 4'b0001, 4'b0000, 16'h0000, 1'b0, 4'h0});
    check("R5 unclocked write absent", 1'b1, 4'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule